// File: doc/BRIEF.md
# Program-Counter Trace Trigger

This block sits beside a processor core and decides, cycle by cycle, whether the trace collection path should record. It watches the retired program counter (qualified by a valid strobe) and the data-memory write bus (address plus write strobe), compares them against values that software has programmed, and drives a single registered trace-enable output.

Two PC gating styles are available. In point mode a start comparator switches trace on and a stop comparator switches it off, and the state persists in between. Interrupt code that runs between those two points is therefore captured even when it lies far from the start address. In range mode, trace is on only while the PC lies strictly inside a programmed window. Independently of the PC mode, a data-write window can be armed. Any qualified write into it fires a sticky kill that ends all tracing until software re-arms the block.

Software programs the block through a narrow write-only register port: a 3-bit register select, a data word and a write strobe.

Top module: `pc_trace_trigger`

## Requirements
- R1: After reset, trace_en is 0, every register reads as zero, all comparators are disabled and the global enable is clear.
- R2: A write with cfg_we=1 stores cfg_wdata into the register chosen by cfg_sel, and the new value is used from the following cycle. The select values are: 0 control, 1 start PC, 2 stop PC, 3 window low, 4 window high, 5 data low, 6 data high, 7 re-arm (not stored). The control bits are: bit0 global enable, bit1 range mode (0 = point mode), bit2 start comparator enable, bit3 stop comparator enable, bit4 PC window enable, bit5 data-kill enable.
- R3: trace_en is registered. Inputs sampled at one clock edge show on trace_en just after that same edge, and trace_en holds until the next edge.
- R4: In point mode, a valid PC equal to the start address with the start comparator enabled turns trace on.
- R5: In point mode, while trace is on, a valid PC equal to the stop address with the stop comparator enabled turns trace off. When both comparators match the same PC, the stop wins if trace is on and the start wins if trace is off.
- R6: In point mode, a cycle with pc_valid low, or a valid PC that matches no enabled comparator, leaves the trace state unchanged. Code that runs outside the start region (for example a pre-empting interrupt) therefore keeps being traced.
- R7: In range mode, each valid PC sets trace on only if the window is enabled and low < PC < high, with both bounds excluded. Otherwise it sets trace off. A cycle with pc_valid low holds the state.
- R8: A comparator whose enable bit is clear never matches, whatever the PC.
- R9: With data-kill enabled, a write (dwr_valid=1) to an address in the inclusive range [data low, data high] forces trace off. The kill stays in force, and overrides any start match or window, until a re-arm. A write with dwr_valid low, or with data-kill disabled, has no effect.
- R10: A write to select 7 clears the kill. If a kill-range write happens in the same cycle as the re-arm, the kill remains set.
- R11: With the global enable clear, trace_en is 0. The programmed values and the trace state are kept, and the state keeps following the PC, so setting the enable again shows the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| pc_valid | input | 1 | Retired PC qualifier |
| pc | input | AW | Retired program counter |
| dwr_valid | input | 1 | Data-memory write strobe |
| dwr_addr | input | AW | Data-memory write address |
| trace_en | output | 1 | Registered trace enable |

## Verification
Every PC or data-write stimulus shows on trace_en one edge later. A register write takes effect one cycle after that, so its effect shows two edges after it is driven. The bench drives inputs on the falling edge and advances its reference model on the rising edge, using the same input values the design samples. It then compares trace_en with the model on the next falling edge, when both have settled. This keeps every comparison aligned to the edge where the result is due.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_START  = 3'd1,
        SEL_STOP   = 3'd2,
        SEL_WIN_LO = 3'd3,
        SEL_WIN_HI = 3'd4,
        SEL_DAT_LO = 3'd5,
        SEL_DAT_HI = 3'd6,
        SEL_REARM  = 3'd7
    } sel_e;

    localparam int CB_GEN   = 0;
    localparam int CB_RANGE = 1;
    localparam int CB_START = 2;
    localparam int CB_STOP  = 3;
    localparam int CB_WIN   = 4;
    localparam int CB_DKILL = 5;
    localparam int CTRL_W   = 6;

    typedef struct packed {
        logic dkill_en;
        logic win_en;
        logic stop_en;
        logic start_en;
        logic range_mode;
        logic gen;
    } ctrl_t;

endpackage

// File: rtl/ptt_cfg_regs.sv
module ptt_cfg_regs
    import ptt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    wdata,
    output ctrl_t            ctrl,
    output logic [AW-1:0]    start_a,
    output logic [AW-1:0]    stop_a,
    output logic [AW-1:0]    win_lo,
    output logic [AW-1:0]    win_hi,
    output logic [AW-1:0]    dat_lo,
    output logic [AW-1:0]    dat_hi,
    output logic             rearm
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [AW-1:0] start_a;
        logic [AW-1:0] stop_a;
        logic [AW-1:0] win_lo;
        logic [AW-1:0] win_hi;
        logic [AW-1:0] dat_lo;
        logic [AW-1:0] dat_hi;
    } regs_t;

    regs_t r_d, r_q;
    ctrl_t ctrl_w;

    always_comb begin
        ctrl_w          = '0;
        ctrl_w.gen      = wdata[CB_GEN];
        ctrl_w.range_mode = wdata[CB_RANGE];
        ctrl_w.start_en = wdata[CB_START];
        ctrl_w.stop_en  = wdata[CB_STOP];
        ctrl_w.win_en   = wdata[CB_WIN];
        ctrl_w.dkill_en = wdata[CB_DKILL];
    end

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel_e'(sel))
                SEL_CTRL:   r_d.ctrl    = ctrl_w;
                SEL_START:  r_d.start_a = wdata;
                SEL_STOP:   r_d.stop_a  = wdata;
                SEL_WIN_LO: r_d.win_lo  = wdata;
                SEL_WIN_HI: r_d.win_hi  = wdata;
                SEL_DAT_LO: r_d.dat_lo  = wdata;
                SEL_DAT_HI: r_d.dat_hi  = wdata;
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl    = r_q.ctrl;
    assign start_a = r_q.start_a;
    assign stop_a  = r_q.stop_a;
    assign win_lo  = r_q.win_lo;
    assign win_hi  = r_q.win_hi;
    assign dat_lo  = r_q.dat_lo;
    assign dat_hi  = r_q.dat_hi;
    assign rearm   = we && (sel == SEL_REARM);

endmodule

// File: rtl/ptt_window.sv
module ptt_window #(
    parameter int AW     = 32,
    parameter bit STRICT = 1'b0
) (
    input  logic          en,
    input  logic          qual,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] value,
    output logic          hit
);

    generate
        if (STRICT) begin : g_open
            assign hit = en && qual && (value > lo) && (value < hi);
        end else begin : g_closed
            assign hit = en && qual && (value >= lo) && (value <= hi);
        end
    endgenerate

endmodule

// File: rtl/ptt_gate.sv
module ptt_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gen,
    input  logic range_mode,
    input  logic pc_valid,
    input  logic start_hit,
    input  logic stop_hit,
    input  logic win_hit,
    input  logic data_hit,
    input  logic rearm,
    output logic trace_en,
    output logic kill_q
);

    typedef struct packed {
        logic on;
        logic kill;
        logic out;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // kill: a hit in the same cycle as a re-arm keeps it set
        if (data_hit)   s_d.kill = 1'b1;
        else if (rearm) s_d.kill = 1'b0;

        if (pc_valid) begin
            if (range_mode) begin
                s_d.on = win_hit;
            end else if (s_q.on && stop_hit) begin
                s_d.on = 1'b0;
            end else if (start_hit) begin
                s_d.on = 1'b1;
            end
        end

        if (s_d.kill) s_d.on = 1'b0;
        s_d.out = gen && s_d.on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trace_en = s_q.out;
    assign kill_q   = s_q.kill;

endmodule

// File: rtl/pc_trace_trigger.sv
module pc_trace_trigger
    import ptt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             pc_valid,
    input  logic [AW-1:0]    pc,
    input  logic             dwr_valid,
    input  logic [AW-1:0]    dwr_addr,
    output logic             trace_en
);

    localparam int NPOINT = 2;

    ctrl_t         ctrl;
    logic [AW-1:0] start_a, stop_a, win_lo, win_hi, dat_lo, dat_hi;
    logic          rearm;
    logic          gen, range_mode, start_en, stop_en, win_en, dkill_en;
    logic          win_hit, data_hit, kill_q;
    logic [NPOINT-1:0]         pt_en;
    logic [NPOINT-1:0][AW-1:0] pt_addr;
    logic [NPOINT-1:0]         pt_hit;

    ptt_cfg_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .ctrl(ctrl), .start_a(start_a), .stop_a(stop_a),
        .win_lo(win_lo), .win_hi(win_hi), .dat_lo(dat_lo), .dat_hi(dat_hi),
        .rearm(rearm)
    );

    assign gen        = ctrl.gen;
    assign range_mode = ctrl.range_mode;
    assign start_en   = ctrl.start_en;
    assign stop_en    = ctrl.stop_en;
    assign win_en     = ctrl.win_en;
    assign dkill_en   = ctrl.dkill_en;

    assign pt_en   = {stop_en, start_en};
    assign pt_addr = {stop_a, start_a};

    genvar g;
    generate
        for (g = 0; g < NPOINT; g++) begin : g_point
            assign pt_hit[g] = pt_en[g] && (pc == pt_addr[g]);
        end
    endgenerate

    ptt_window #(.AW(AW), .STRICT(1'b1)) u_pcwin (
        .en(win_en), .qual(pc_valid), .lo(win_lo), .hi(win_hi),
        .value(pc), .hit(win_hit)
    );

    ptt_window #(.AW(AW), .STRICT(1'b0)) u_dwin (
        .en(dkill_en), .qual(dwr_valid), .lo(dat_lo), .hi(dat_hi),
        .value(dwr_addr), .hit(data_hit)
    );

    ptt_gate u_gate (
        .clk(clk), .rst_n(rst_n), .gen(gen), .range_mode(range_mode),
        .pc_valid(pc_valid), .start_hit(pt_hit[0]), .stop_hit(pt_hit[1]),
        .win_hit(win_hit), .data_hit(data_hit), .rearm(rearm),
        .trace_en(trace_en), .kill_q(kill_q)
    );

endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [2:0]    cfg_sel,
    input logic          pc_valid,
    input logic [AW-1:0] pc,
    input logic          dwr_valid,
    input logic [AW-1:0] dwr_addr,
    input logic          trace_en,
    input logic          gen,
    input logic          range_mode,
    input logic          start_en,
    input logic          stop_en,
    input logic          win_en,
    input logic          dkill_en,
    input logic [AW-1:0] start_a,
    input logic [AW-1:0] stop_a,
    input logic [AW-1:0] win_lo,
    input logic [AW-1:0] win_hi,
    input logic [AW-1:0] dat_lo,
    input logic [AW-1:0] dat_hi,
    input logic          kill_q
);

    logic dhit_c;
    assign dhit_c = dkill_en && dwr_valid && dwr_addr >= dat_lo && dwr_addr <= dat_hi;

    AST_GEN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> !trace_en); // R11

    AST_DATA_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        dhit_c |=> !trace_en); // R9

    AST_KILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_q && !(cfg_we && cfg_sel == 3'd7)) |=> !trace_en); // R10

    AST_START_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && !range_mode && pc_valid && start_en && pc == start_a &&
         !(stop_en && pc == stop_a) && !kill_q && !dhit_c) |=> trace_en); // R4

    AST_RANGE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (gen && range_mode && win_en && pc_valid && pc > win_lo && pc < win_hi &&
         !kill_q && !dhit_c) |=> trace_en); // R7

    AST_RANGE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (range_mode && pc_valid && (pc <= win_lo || pc >= win_hi)) |=> !trace_en); // R7

    AST_POINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!range_mode && !pc_valid && !dhit_c && !cfg_we && gen && $stable(gen))
        |=> trace_en == $past(trace_en)); // R6

endmodule

bind pc_trace_trigger ptt_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .pc_valid(pc_valid), .pc(pc), .dwr_valid(dwr_valid), .dwr_addr(dwr_addr),
    .trace_en(trace_en), .gen(gen), .range_mode(range_mode),
    .start_en(start_en), .stop_en(stop_en), .win_en(win_en), .dkill_en(dkill_en),
    .start_a(start_a), .stop_a(stop_a), .win_lo(win_lo), .win_hi(win_hi),
    .dat_lo(dat_lo), .dat_hi(dat_hi), .kill_q(kill_q)
);

// File: tb/pc_trace_trigger_test.sv
`timescale 1ns/1ps
module pc_trace_trigger_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc = 32'd0;
    logic        dwr_valid = 1'b0;
    logic [31:0] dwr_addr = 32'd0;
    logic        trace_en;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit          m_gen, m_range, m_sten, m_spen, m_wen, m_den;
    logic [31:0] m_start, m_stop, m_wlo, m_whi, m_dlo, m_dhi;
    bit          m_on, m_kill, m_exp;

    always #5 clk = ~clk;

    pc_trace_trigger #(.AW(32)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pc_valid(pc_valid), .pc(pc),
        .dwr_valid(dwr_valid), .dwr_addr(dwr_addr), .trace_en(trace_en)
    );

    always @(posedge clk) begin
        bit dhit, st;
        if (!rst_n) begin
            {m_gen, m_range, m_sten, m_spen, m_wen, m_den} = '0;
            m_start = 0; m_stop = 0; m_wlo = 0; m_whi = 0; m_dlo = 0; m_dhi = 0;
            m_on = 0; m_kill = 0; m_exp = 0;
        end else begin
            dhit = m_den && dwr_valid && dwr_addr >= m_dlo && dwr_addr <= m_dhi;
            if (dhit) m_kill = 1;
            else if (cfg_we && cfg_sel == 3'd7) m_kill = 0;
            st = m_on;
            if (pc_valid) begin
                if (m_range) st = m_wen && pc > m_wlo && pc < m_whi;
                else if (m_on && m_spen && pc == m_stop) st = 0;
                else if (m_sten && pc == m_start) st = 1;
            end
            if (m_kill) st = 0;
            m_on = st;
            m_exp = m_gen && st;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: begin
                        m_gen = cfg_wdata[0]; m_range = cfg_wdata[1]; m_sten = cfg_wdata[2];
                        m_spen = cfg_wdata[3]; m_wen = cfg_wdata[4]; m_den = cfg_wdata[5];
                    end
                    3'd1: m_start = cfg_wdata;
                    3'd2: m_stop = cfg_wdata;
                    3'd3: m_wlo = cfg_wdata;
                    3'd4: m_whi = cfg_wdata;
                    3'd5: m_dlo = cfg_wdata;
                    3'd6: m_dhi = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (trace_en !== m_exp) begin
                miscompares++;
                $display("FAIL %s: trace_en=%0b expected %0b at cycle %0d",
                         cur_req, trace_en, m_exp, cycles);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 0; pc_valid = 0; dwr_valid = 0;
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        pc_valid = 0; dwr_valid = 0;
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic step_pc(input logic [31:0] a);
        @(negedge clk);
        cfg_we = 0; dwr_valid = 0;
        pc_valid = 1; pc = a;
    endtask

    task automatic step_wr(input logic [31:0] a, input logic v);
        @(negedge clk);
        cfg_we = 0; pc_valid = 0;
        dwr_valid = v; dwr_addr = a;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(2);

        // R2: program point mode (gen|start|stop = 0x0D)
        cur_req = "R2";
        wr(3'd1, 32'h100);
        wr(3'd2, 32'h200);
        wr(3'd0, 32'h0D);

        // R4 / R3: start match, result on the next edge
        cur_req = "R4";
        step_pc(32'h80);
        step_pc(32'h100);
        cur_req = "R6";
        step_pc(32'h104);
        step_pc(32'h3000);   // pre-empting interrupt code
        step_pc(32'h3004);
        idle(3);
        step_pc(32'h108);
        cur_req = "R5";
        step_pc(32'h200);
        step_pc(32'h204);
        idle(2);

        // R8: start comparator disabled (gen|stop = 0x09)
        cur_req = "R8";
        wr(3'd0, 32'h09);
        step_pc(32'h100);
        step_pc(32'h100);
        idle(1);

        // R5: both comparators on one address
        cur_req = "R5";
        wr(3'd2, 32'h100);
        wr(3'd0, 32'h0D);
        step_pc(32'h100);
        step_pc(32'h100);
        step_pc(32'h100);
        idle(1);
        wr(3'd2, 32'h200);

        // R11: global enable gating
        cur_req = "R11";
        step_pc(32'h100);
        wr(3'd0, 32'h0C);
        step_pc(32'h150);
        step_pc(32'h200);
        step_pc(32'h100);
        idle(1);
        wr(3'd0, 32'h0D);
        idle(2);
        step_pc(32'h200);
        idle(1);

        // R7: range mode, window (0x400, 0x500), ctrl gen|range|win = 0x13
        cur_req = "R7";
        wr(3'd3, 32'h400);
        wr(3'd4, 32'h500);
        wr(3'd0, 32'h13);
        step_pc(32'h400);
        step_pc(32'h401);
        idle(2);
        step_pc(32'h4FF);
        step_pc(32'h500);
        step_pc(32'h450);
        step_pc(32'h3FF);
        step_pc(32'h450);
        cur_req = "R8";
        wr(3'd0, 32'h03);   // window disabled
        step_pc(32'h450);
        idle(1);

        // R9: data kill [0x8000, 0x80FF], ctrl gen|start|stop|dkill = 0x2D
        cur_req = "R9";
        wr(3'd5, 32'h8000);
        wr(3'd6, 32'h80FF);
        wr(3'd0, 32'h2D);
        step_pc(32'h100);
        step_wr(32'h7FFF, 1);
        step_wr(32'h8050, 0);
        step_wr(32'h8100, 1);
        step_wr(32'h8000, 1);
        step_pc(32'h100);
        step_pc(32'h104);
        idle(2);

        // R10: re-arm, then start works again
        cur_req = "R10";
        wr(3'd7, 32'h0);
        step_pc(32'h100);
        step_wr(32'h80FF, 1);
        step_pc(32'h100);
        // re-arm coinciding with a kill hit: kill stays
        @(negedge clk);
        pc_valid = 0; cfg_we = 1; cfg_sel = 3'd7; dwr_valid = 1; dwr_addr = 32'h8001;
        step_pc(32'h100);
        idle(1);
        wr(3'd7, 32'h0);
        step_pc(32'h100);
        cur_req = "R9";
        wr(3'd0, 32'h0D);   // data-kill disabled
        step_wr(32'h8010, 1);
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule